// File: doc/BRIEF.md
# USB Power-Up Sequencer

This block is a hardware state machine that brings a USB peripheral's clock and power chain up after reset, with no firmware involved. It first enables the frequency synthesizer and waits a fixed interval. It then polls the synthesizer lock flag at a fixed retry interval. Once lock is seen, it switches on the DC-DC regulator in high-current mode. It waits a settle time derived from the external capacitor value, gates on the USB clock, and after a short gap of system clocks it enables the USB function controller.

All waits are counted in ticks of 0.1 ms. A parameter sets how many system clocks make one tick. The regulator settle time is (C+1) ms, where C is the capacitor value in µF. The parameter supplies C in tenths of a µF, so the wait is C_tenths+10 ticks; for example, 2.2 µF gives 32 ticks.

Once the sequence has finished, a suspend input selects the regulator's low-current mode. An optional retry limit turns an endless lock search into a sticky error. The current state is driven out on `state_o` so the ordering can be observed.

The states and their transitions are as follows:
- IDLE=0 → PLL_WAIT=1 after one cycle.
- PLL_WAIT → REG_SETTLE=3 if lock is seen at the sample, or → LOCK_RETRY=2 if it is not.
- LOCK_RETRY → REG_SETTLE on lock, back to itself on no lock, or → FAULT=6 once the retry limit is used up.
- REG_SETTLE → CLK_GAP=4.
- CLK_GAP → READY=5.
- From any state, a reset or `illegal_op` returns the machine to IDLE.

Top module: `usb_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `illegal_op` is sampled high, the block is in IDLE (`state_o`=0). In IDLE every enable output is 0, and `ready` and `lock_err` are 0.
- R2: IDLE lasts one cycle. The block then enters PLL_WAIT (`state_o`=1) with `pll_en`=1 and stays there for exactly 20 ticks. A tick is CLKS_PER_TICK clocks. Lock is sampled in the last cycle of that wait.
- R3: If lock reads 0 at a sample, the block enters LOCK_RETRY (`state_o`=2). It samples lock again at the end of every further 1-tick wait until lock reads 1.
- R4: When lock reads 1 at a sample, the block enters REG_SETTLE (`state_o`=3) with `reg_en`=1 and `reg_lowcur`=0 (high-current mode).
- R5: REG_SETTLE lasts exactly CAP_TENTHS_UF+10 ticks, which is (C+1) ms.
- R6: After REG_SETTLE, the block enters CLK_GAP (`state_o`=4) with `usbclk_en`=1. `usbclk_en` is never 1 before that point.
- R7: CLK_GAP lasts USB_GAP_CLKS system clocks (default 4, at least 4). The block then enters READY (`state_o`=5) with `fcu_en`=1 and `ready`=1.
- R8: `reg_lowcur` follows `usb_suspend` only in READY and is 0 in every other state. Deasserting `usb_suspend` restores high-current mode without leaving READY.
- R9: With MAX_RETRIES nonzero, the block enters FAULT (`state_o`=6) when that many retry samples in a row read 0. In FAULT, `lock_err`=1, `pll_en`=1 and all other enables are 0. FAULT holds until a reset, whatever lock does. With MAX_RETRIES=0 the block retries without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, already qualified for minimum width |
| illegal_op | input | 1 | Synchronous restart request from the processor (invalid-opcode event) |
| pll_lock | input | 1 | Synthesizer lock flag |
| usb_suspend | input | 1 | USB suspend in effect |
| pll_en | output | 1 | Frequency synthesizer enable |
| reg_en | output | 1 | DC-DC regulator enable |
| reg_lowcur | output | 1 | Regulator low-current mode select |
| usbclk_en | output | 1 | USB clock gate enable |
| fcu_en | output | 1 | USB function controller enable |
| ready | output | 1 | Sequence complete |
| lock_err | output | 1 | Sticky lock-timeout error |
| state_o | output | 3 | Current sequencer state |

## Verification
- **State, enables and flags.** Each is a combinational function of the state register, so it changes in the same cycle as the state, one clock edge after the condition that caused the change.
- **Suspend select.** `reg_lowcur` follows `usb_suspend` within the same cycle while the block is in READY.
- **Dwell times.** Each wait of N ticks holds its state for exactly N·CLKS_PER_TICK cycles counted from entry. The clock gap holds for USB_GAP_CLKS cycles.
- **Bench method.** A behavioural model counts the elapsed cycles in each state and advances on the same edges. It is compared with every output one nanosecond after each rising edge, well before the inputs change at the falling edge. Measured edge-to-edge intervals confirm the 20-tick, settle and gap lengths.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_PLL_WAIT   = 3'd1,
        ST_LOCK_RETRY = 3'd2,
        ST_REG_SETTLE = 3'd3,
        ST_CLK_GAP    = 3'd4,
        ST_READY      = 3'd5,
        ST_FAULT      = 3'd6
    } seq_state_t;
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
    parameter int CLKS_PER_TICK = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int SUB_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_TICK - 1);

    logic [SUB_W-1:0] sub_q;

    assign tick = (sub_q == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sub_q <= '0;
        else if (clear || tick)
            sub_q <= '0;
        else
            sub_q <= sub_q + 1'b1;
    end
endmodule

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // done marks the final step of a wait of 'target' units
    assign done = step && (cnt_q == target - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import usb_pwrup_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int LOCK_TICKS   = 20,
    parameter int RETRY_TICKS  = 1,
    parameter int SETTLE_TICKS = 32,
    parameter int GAP_CLKS     = 4,
    parameter int MAX_RETRIES  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             illegal_op,
    input  logic             pll_lock,
    input  logic             usb_suspend,
    input  logic             wait_done,
    output logic             restart,
    output logic             step_per_clk,
    output logic [CNT_W-1:0] target,
    output logic             pll_en,
    output logic             reg_en,
    output logic             reg_lowcur,
    output logic             usbclk_en,
    output logic             fcu_en,
    output logic             ready,
    output logic             lock_err,
    output logic [2:0]       state_o
);
    localparam int RC_W = $clog2(MAX_RETRIES + 2);

    seq_state_t      state_q, state_d;
    logic [RC_W-1:0] retry_q, retry_d;
    logic            retry_again;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            retry_q <= retry_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d     = state_q;
        retry_d     = retry_q;
        retry_again = 1'b0;
        if (illegal_op) begin
            state_d = ST_IDLE;
            retry_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_PLL_WAIT;
                    retry_d = '0;
                end
                ST_PLL_WAIT: if (wait_done) begin
                    if (pll_lock) begin
                        state_d = ST_REG_SETTLE;
                    end else begin
                        state_d = ST_LOCK_RETRY;
                        retry_d = RC_W'(1);
                    end
                end
                ST_LOCK_RETRY: if (wait_done) begin
                    if (pll_lock)
                        state_d = ST_REG_SETTLE;
                    else if (MAX_RETRIES != 0 && retry_q == RC_W'(MAX_RETRIES))
                        state_d = ST_FAULT;
                    else begin
                        retry_again = 1'b1;
                        if (MAX_RETRIES != 0)
                            retry_d = retry_q + 1'b1;
                    end
                end
                ST_REG_SETTLE: if (wait_done) state_d = ST_CLK_GAP;
                ST_CLK_GAP:    if (wait_done) state_d = ST_READY;
                ST_READY:      state_d = ST_READY;
                ST_FAULT:      state_d = ST_FAULT;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    assign restart = (state_d != state_q) || retry_again;

    // outputs and timer control
    always_comb begin
        pll_en       = 1'b0;
        reg_en       = 1'b0;
        reg_lowcur   = 1'b0;
        usbclk_en    = 1'b0;
        fcu_en       = 1'b0;
        ready        = 1'b0;
        lock_err     = 1'b0;
        step_per_clk = 1'b0;
        target       = CNT_W'(LOCK_TICKS);
        unique case (state_q)
            ST_IDLE: ;
            ST_PLL_WAIT: pll_en = 1'b1;
            ST_LOCK_RETRY: begin
                pll_en = 1'b1;
                target = CNT_W'(RETRY_TICKS);
            end
            ST_REG_SETTLE: begin
                pll_en = 1'b1;
                reg_en = 1'b1;
                target = CNT_W'(SETTLE_TICKS);
            end
            ST_CLK_GAP: begin
                pll_en       = 1'b1;
                reg_en       = 1'b1;
                usbclk_en    = 1'b1;
                step_per_clk = 1'b1;
                target       = CNT_W'(GAP_CLKS);
            end
            ST_READY: begin
                pll_en     = 1'b1;
                reg_en     = 1'b1;
                usbclk_en  = 1'b1;
                fcu_en     = 1'b1;
                ready      = 1'b1;
                reg_lowcur = usb_suspend;
            end
            ST_FAULT: begin
                pll_en   = 1'b1;
                lock_err = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq #(
    parameter int CLKS_PER_TICK = 5000,
    parameter int CAP_TENTHS_UF = 22,
    parameter int USB_GAP_CLKS  = 4,
    parameter int MAX_RETRIES   = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       illegal_op,
    input  logic       pll_lock,
    input  logic       usb_suspend,
    output logic       pll_en,
    output logic       reg_en,
    output logic       reg_lowcur,
    output logic       usbclk_en,
    output logic       fcu_en,
    output logic       ready,
    output logic       lock_err,
    output logic [2:0] state_o
);
    localparam int LOCK_TICKS   = 20;
    localparam int RETRY_TICKS  = 1;
    localparam int SETTLE_TICKS = CAP_TENTHS_UF + 10;
    localparam int GAP_CLKS     = (USB_GAP_CLKS < 4) ? 4 : USB_GAP_CLKS;
    localparam int MAX_T1       = (SETTLE_TICKS > LOCK_TICKS) ? SETTLE_TICKS : LOCK_TICKS;
    localparam int MAX_TGT      = (GAP_CLKS > MAX_T1) ? GAP_CLKS : MAX_T1;
    localparam int CNT_W        = $clog2(MAX_TGT + 1);

    logic             restart, step_per_clk, tick, wait_done;
    logic [CNT_W-1:0] target;

    pwr_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (tick)
    );

    pwr_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .step   (step_per_clk | tick),
        .target (target),
        .done   (wait_done)
    );

    pwr_seq_fsm #(
        .CNT_W        (CNT_W),
        .LOCK_TICKS   (LOCK_TICKS),
        .RETRY_TICKS  (RETRY_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .GAP_CLKS     (GAP_CLKS),
        .MAX_RETRIES  (MAX_RETRIES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .illegal_op   (illegal_op),
        .pll_lock     (pll_lock),
        .usb_suspend  (usb_suspend),
        .wait_done    (wait_done),
        .restart      (restart),
        .step_per_clk (step_per_clk),
        .target       (target),
        .pll_en       (pll_en),
        .reg_en       (reg_en),
        .reg_lowcur   (reg_lowcur),
        .usbclk_en    (usbclk_en),
        .fcu_en       (fcu_en),
        .ready        (ready),
        .lock_err     (lock_err),
        .state_o      (state_o)
    );
endmodule

// File: rtl/usb_pwrup_seq_chk.sv
module usb_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       illegal_op,
    input logic       pll_lock,
    input logic       usb_suspend,
    input logic       pll_en,
    input logic       reg_en,
    input logic       reg_lowcur,
    input logic       usbclk_en,
    input logic       fcu_en,
    input logic       ready,
    input logic       lock_err,
    input logic [2:0] state_o
);
    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> (state_o == 3'd0) && !pll_en && !reg_en && !usbclk_en && !fcu_en && !lock_err); // R1

    AST_REG_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_en) |-> $past(pll_lock)); // R4

    AST_CLK_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usbclk_en) |-> $past(reg_en) && ($past(state_o) == 3'd3)); // R6

    AST_FCU_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fcu_en) |-> $past(usbclk_en, 4)); // R7

    AST_LOWCUR_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lowcur |-> ready && usb_suspend); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && !illegal_op) |=> lock_err); // R9
endmodule

bind usb_pwrup_seq usb_pwrup_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .illegal_op  (illegal_op),
    .pll_lock    (pll_lock),
    .usb_suspend (usb_suspend),
    .pll_en      (pll_en),
    .reg_en      (reg_en),
    .reg_lowcur  (reg_lowcur),
    .usbclk_en   (usbclk_en),
    .fcu_en      (fcu_en),
    .ready       (ready),
    .lock_err    (lock_err),
    .state_o     (state_o)
);

// File: tb/usb_pwrup_seq_tb.sv
`timescale 1ns/1ps
module usb_pwrup_seq_tb;
    localparam int CPT  = 4;
    localparam int CAP  = 22;
    localparam int GAP  = 4;
    localparam int MAXR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic illegal_op = 1'b0;
    logic pll_lock = 1'b0;
    logic usb_suspend = 1'b0;
    logic pll_en, reg_en, reg_lowcur, usbclk_en, fcu_en, ready, lock_err;
    logic [2:0] state_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_pwrup_seq #(
        .CLKS_PER_TICK (CPT),
        .CAP_TENTHS_UF (CAP),
        .USB_GAP_CLKS  (GAP),
        .MAX_RETRIES   (MAXR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .illegal_op(illegal_op), .pll_lock(pll_lock),
        .usb_suspend(usb_suspend), .pll_en(pll_en), .reg_en(reg_en),
        .reg_lowcur(reg_lowcur), .usbclk_en(usbclk_en), .fcu_en(fcu_en),
        .ready(ready), .lock_err(lock_err), .state_o(state_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model: state number and cycles spent in it
    int ms = 0, el = 0, rc = 0;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n || illegal_op) begin
            ms = 0; el = 0; rc = 0;
        end else begin
            case (ms)
                0: begin ms = 1; el = 0; end
                1: begin
                    el++;
                    if (el == 20 * CPT) begin
                        el = 0;
                        if (pll_lock) ms = 3; else begin ms = 2; rc = 1; end
                    end
                end
                2: begin
                    el++;
                    if (el == CPT) begin
                        el = 0;
                        if (pll_lock) ms = 3;
                        else if (rc == MAXR) ms = 6;
                        else rc++;
                    end
                end
                3: begin
                    el++;
                    if (el == (CAP + 10) * CPT) begin el = 0; ms = 4; end
                end
                4: begin
                    el++;
                    if (el == GAP) begin el = 0; ms = 5; end
                end
                default: ;
            endcase
        end
    end

    // compare one time unit after each rising edge
    int t_pll = 0, t_reg = 0, t_clk = 0, t_fcu = 0;
    logic p_pll = 0, p_reg = 0, p_clk = 0, p_fcu = 0;
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R1/R2", "state_o", state_o, ms);
            chk("R2", "pll_en", pll_en, (ms != 0) ? 1 : 0);
            chk("R4", "reg_en", reg_en, (ms >= 3 && ms <= 5) ? 1 : 0);
            chk("R8", "reg_lowcur", reg_lowcur, (ms == 5 && usb_suspend) ? 1 : 0);
            chk("R6", "usbclk_en", usbclk_en, (ms == 4 || ms == 5) ? 1 : 0);
            chk("R7", "fcu_en", fcu_en, (ms == 5) ? 1 : 0);
            chk("R7", "ready", ready, (ms == 5) ? 1 : 0);
            chk("R9", "lock_err", lock_err, (ms == 6) ? 1 : 0);
            if (pll_en && !p_pll) t_pll = cyc;
            if (reg_en && !p_reg) t_reg = cyc;
            if (usbclk_en && !p_clk) t_clk = cyc;
            if (fcu_en && !p_fcu) t_fcu = cyc;
            p_pll = pll_en; p_reg = reg_en; p_clk = usbclk_en; p_fcu = fcu_en;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_state(input int s);
        for (int i = 0; i < 2000 && state_o != 3'(s); i++) @(negedge clk);
    endtask

    task automatic pulse_illegal();
        @(negedge clk);
        illegal_op = 1'b1;
        @(negedge clk);
        illegal_op = 1'b0;
    endtask

    initial begin
        // R1: reset state
        pll_lock = 1'b1;
        usb_suspend = 1'b1;   // R8: ignored until READY
        cycles(3);
        chk("R1", "state in reset", state_o, 0);
        chk("R1", "pll_en in reset", pll_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_state(5);
        cycles(2);
        chk("R2", "PLL wait length", t_reg - t_pll, 20 * CPT);
        chk("R5", "settle length", t_clk - t_reg, (CAP + 10) * CPT);
        chk("R7", "clock gap", t_fcu - t_clk, GAP);
        chk("R8", "low current in suspend", reg_lowcur, 1);
        usb_suspend = 1'b0;
        cycles(5);
        chk("R8", "high current after resume", reg_lowcur, 0);
        chk("R8", "still ready after resume", ready, 1);
        usb_suspend = 1'b1;
        cycles(3);
        usb_suspend = 1'b0;

        // R1/R3: restart by illegal opcode, lock arrives during retries
        pll_lock = 1'b0;
        pulse_illegal();
        wait_state(2);
        cycles(2 * CPT + 1);
        pll_lock = 1'b1;
        wait_state(5);
        chk("R3", "ready after late lock", ready, 1);

        // R1: restart in the middle of regulator settle
        pulse_illegal();
        wait_state(3);
        cycles(10);
        pulse_illegal();
        chk("R1", "reg_en dropped on restart", reg_en, 0);
        wait_state(5);
        cycles(3);

        // R9: lock never comes -> fault, sticky
        pll_lock = 1'b0;
        pulse_illegal();
        wait_state(6);
        chk("R9", "fault state", state_o, 6);
        cycles(5);
        pll_lock = 1'b1;
        cycles(30);
        chk("R9", "fault sticky with lock", lock_err, 1);
        rst_n = 1'b0;
        cycles(2);
        chk("R1", "lock_err cleared by reset", lock_err, 0);
        rst_n = 1'b1;
        wait_state(5);
        cycles(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule